// File: doc/BRIEF.md
# ECAM Host Bridge Request Decoder

This block stands between a hart-side memory-mapped port and a simplified PCIe request port. Each hart access is classified by address. Accesses inside the configuration window become configuration read or write requests. The bus, device, function and register fields are cut directly from the address offset. Accesses inside the outbound region are passed on as memory requests, but only when their page lies in one of the programmed windows. All other accesses are answered locally with an error.

Configuration reads to functions that do not exist on the root bus are answered locally with all-ones data, and no request is sent. A configuration write to such a function is acknowledged and dropped. A configuration read whose completion reports Unsupported Request also returns all ones. The bridge handles one access at a time. The hart keeps its request valid until a one-cycle response pulse comes back.

Top module: `ecam_host_decoder`

## Requirements
- R1: A hart read whose address bits [AW-1:28] equal `ecam_base_hi` issues a request of kind 0 (config read). `p_req_id` is {addr[27:20] bus, addr[19:15] device, addr[14:12] function}, `p_req_reg` is addr[11:0], and `p_req_addr` is the hart address.
- R2: A hart write in the configuration window issues a request of kind 1 (config write). It carries the hart strobe as `p_req_be` and the hart write data.
- R3: A hart access outside the configuration window, inside the outbound page range [`out_base_pg`, `out_limit_pg`] and inside a window, issues a memory request. The kind is 2 for a read and 3 for a write. The request carries the full address, and `p_req_id` and `p_req_reg` are zero.
- R4: Any other access, including an outbound access in no window, issues no request. It receives a response with `h_rsp_err`=1 and zero data.
- R5: A window covers the 4 KiB pages from its base to its limit, and both ends are included. A window whose base page is above its limit page matches nothing.
- R6: A config read to bus `ROOT_BUS` whose presence bit {device,function} is 0 issues no request. It returns all-ones data with no error.
- R7: A config write to such an absent function issues no request. It is acknowledged with no error.
- R8: A config completion returns its data to the hart. A config read completion flagged Unsupported Request returns all ones with no error.
- R9: A memory read completion flagged Unsupported Request returns an error with zero data.
- R10: Only one access is in flight at a time. `p_req_valid` and its fields stay stable until `p_req_ready`. `h_rsp_valid` is a single-cycle pulse.
- R11: A memory write is acknowledged once its request is accepted, with no completion awaited.
- R12: During and straight after reset, neither `p_req_valid` nor `h_rsp_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req_valid | input | 1 | Hart access pending, held until response |
| h_req_write | input | 1 | 1 = write |
| h_req_addr | input | AW | Hart byte address |
| h_req_wdata | input | DW | Write data |
| h_req_strb | input | DW/8 | Byte strobes |
| h_rsp_valid | output | 1 | One-cycle response pulse |
| h_rsp_rdata | output | DW | Read data |
| h_rsp_err | output | 1 | Error response |
| ecam_base_hi | input | AW-28 | Upper address bits of the config window |
| out_base_pg | input | AW-12 | First page of outbound region |
| out_limit_pg | input | AW-12 | Last page of outbound region |
| win_base_pg | input | NWIN*(AW-12) | Per-window first page, packed |
| win_limit_pg | input | NWIN*(AW-12) | Per-window last page, packed |
| fn_present | input | 256 | Root-bus presence map indexed {device,function} |
| p_req_valid | output | 1 | Request valid |
| p_req_ready | input | 1 | Request accepted |
| p_req_kind | output | 2 | 0 cfg rd, 1 cfg wr, 2 mem rd, 3 mem wr |
| p_req_addr | output | AW | Request address |
| p_req_id | output | 16 | {bus, device, function} for config |
| p_req_reg | output | 12 | Config register offset |
| p_req_be | output | DW/8 | Byte enables |
| p_req_wdata | output | DW | Write data |
| p_cpl_valid | input | 1 | Completion valid |
| p_cpl_ur | input | 1 | Completion reports Unsupported Request |
| p_cpl_data | input | DW | Completion data |

## Verification
A locally answered access produces its response pulse one cycle after the edge where the bridge accepts it, with no request in between. A forwarded request appears one cycle after acceptance and remains until the ready edge. A posted write's response follows one cycle after that edge. Other responses come one cycle after the completion edge. The bench does not pin these latencies to fixed cycle numbers. A driver queues the expected request and response for each access. Monitors sample at the falling edge, where each pulse or handshake is seen exactly once, and compare in order. Any expected request still queued at the end counts as a failure.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    K_CFG_RD = 2'd0,
    K_CFG_WR = 2'd1,
    K_MEM_RD = 2'd2,
    K_MEM_WR = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    C_FWD    = 2'd0,
    C_ERR    = 2'd1,
    C_ABSENT = 2'd2
  } dec_cls_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } st_e;
endpackage

// File: rtl/hbd_win_match.sv
module hbd_win_match #(
  parameter int AW   = 32,
  parameter int NWIN = 3,
  localparam int PGW = AW - 12
) (
  input  logic [PGW-1:0]      pg,
  input  logic [NWIN*PGW-1:0] base_pg,
  input  logic [NWIN*PGW-1:0] limit_pg,
  output logic                any_hit
);
  logic [NWIN-1:0] hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [PGW-1:0] b, l;
    assign b = base_pg[i*PGW +: PGW];
    assign l = limit_pg[i*PGW +: PGW];
    // inclusive bounds; inverted window is disabled (R5)
    assign hit[i] = (b <= l) && (pg >= b) && (pg <= l);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/hbd_decode.sv
module hbd_decode
  import hbd_pkg::*;
#(
  parameter int         AW       = 32,
  parameter logic [7:0] ROOT_BUS = 8'h00,
  localparam int PGW = AW - 12,
  localparam int EHW = AW - 28,
  localparam int NFN = 256
) (
  input  logic           write,
  input  logic [AW-1:0]  addr,
  input  logic [EHW-1:0] ecam_base_hi,
  input  logic [PGW-1:0] out_base_pg,
  input  logic [PGW-1:0] out_limit_pg,
  input  logic           win_hit,
  input  logic [NFN-1:0] fn_present,
  output dec_cls_e       cls,
  output req_kind_e      kind,
  output logic [7:0]     bus,
  output logic [4:0]     dev,
  output logic [2:0]     fn,
  output logic [11:0]    regoff
);
  logic           in_ecam, in_out;
  logic [PGW-1:0] pg;

  assign bus    = addr[27:20];
  assign dev    = addr[19:15];
  assign fn     = addr[14:12];
  assign regoff = addr[11:0];
  assign pg     = addr[AW-1:12];

  always_comb begin
    in_ecam = (addr[AW-1:28] == ecam_base_hi);
    in_out  = (pg >= out_base_pg) && (pg <= out_limit_pg);
    if (in_ecam) begin
      kind = write ? K_CFG_WR : K_CFG_RD;
      cls  = ((bus == ROOT_BUS) && !fn_present[{dev, fn}]) ? C_ABSENT : C_FWD;
    end else if (in_out && win_hit) begin
      kind = write ? K_MEM_WR : K_MEM_RD;
      cls  = C_FWD;
    end else begin
      kind = write ? K_MEM_WR : K_MEM_RD;
      cls  = C_ERR;
    end
  end
endmodule

// File: rtl/hbd_ctrl.sv
module hbd_ctrl
  import hbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req_valid,
  input  logic [AW-1:0] h_req_addr,
  input  logic [DW-1:0] h_req_wdata,
  input  logic [BW-1:0] h_req_strb,
  input  dec_cls_e      cls,
  input  req_kind_e     kind,
  input  logic [15:0]   cfg_id,
  input  logic [11:0]   cfg_reg,
  output logic          h_rsp_valid,
  output logic [DW-1:0] h_rsp_rdata,
  output logic          h_rsp_err,
  output logic          p_req_valid,
  input  logic          p_req_ready,
  output req_kind_e     p_req_kind,
  output logic [AW-1:0] p_req_addr,
  output logic [15:0]   p_req_id,
  output logic [11:0]   p_req_reg,
  output logic [BW-1:0] p_req_be,
  output logic [DW-1:0] p_req_wdata,
  input  logic          p_cpl_valid,
  input  logic          p_cpl_ur,
  input  logic [DW-1:0] p_cpl_data
);
  st_e           st_q, st_d;
  req_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   id_q, id_d;
  logic [11:0]   reg_q, reg_d;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;
  logic          err_q, err_d, ld_req, ld_rsp;
  logic          is_cfg;

  assign is_cfg = (kind == K_CFG_RD) || (kind == K_CFG_WR);

  always_comb begin
    st_d    = st_q;
    ld_req  = 1'b0;
    ld_rsp  = 1'b0;
    rdata_d = '0;
    err_d   = 1'b0;
    id_d    = is_cfg ? cfg_id  : 16'h0;
    reg_d   = is_cfg ? cfg_reg : 12'h0;
    case (st_q)
      S_IDLE: if (h_req_valid) begin
        ld_req = 1'b1;
        case (cls)
          C_FWD: st_d = S_ISSUE;
          C_ABSENT: begin
            st_d    = S_RESP;
            ld_rsp  = 1'b1;
            rdata_d = (kind == K_CFG_RD) ? '1 : '0;
          end
          default: begin
            st_d   = S_RESP;
            ld_rsp = 1'b1;
            err_d  = 1'b1;
          end
        endcase
      end
      S_ISSUE: if (p_req_ready) begin
        if (kind_q == K_MEM_WR) begin
          st_d   = S_RESP;
          ld_rsp = 1'b1;
        end else begin
          st_d = S_WAIT;
        end
      end
      S_WAIT: if (p_cpl_valid) begin
        st_d   = S_RESP;
        ld_rsp = 1'b1;
        case (kind_q)
          K_CFG_RD: rdata_d = p_cpl_ur ? '1 : p_cpl_data;
          K_MEM_RD: begin
            rdata_d = p_cpl_ur ? '0 : p_cpl_data;
            err_d   = p_cpl_ur;
          end
          default: rdata_d = '0;
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      kind_q  <= K_CFG_RD;
      addr_q  <= '0;
      id_q    <= '0;
      reg_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_req) begin
        kind_q  <= kind;
        addr_q  <= h_req_addr;
        id_q    <= id_d;
        reg_q   <= reg_d;
        be_q    <= h_req_strb;
        wdata_q <= h_req_wdata;
      end
      if (ld_rsp) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end
    end
  end

  assign p_req_valid = (st_q == S_ISSUE);
  assign h_rsp_valid = (st_q == S_RESP);
  assign p_req_kind  = kind_q;
  assign p_req_addr  = addr_q;
  assign p_req_id    = id_q;
  assign p_req_reg   = reg_q;
  assign p_req_be    = be_q;
  assign p_req_wdata = wdata_q;
  assign h_rsp_rdata = rdata_q;
  assign h_rsp_err   = err_q;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req_valid && !p_req_ready) |=>
      (p_req_valid && $stable(p_req_kind) && $stable(p_req_addr) && $stable(p_req_wdata)));

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |=> !h_rsp_valid);

  a_r10_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_req_valid) |-> $past(h_req_valid));

  a_r8_ur_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && p_cpl_valid && p_cpl_ur && kind_q == K_CFG_RD) |=>
      (h_rsp_valid && h_rsp_rdata == '1 && !h_rsp_err));

  a_r9_ur_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && p_cpl_valid && p_cpl_ur && kind_q == K_MEM_RD) |=>
      (h_rsp_valid && h_rsp_err));

  a_r12_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> (!p_req_valid && !h_rsp_valid));
endmodule

// File: rtl/ecam_host_decoder.sv
module ecam_host_decoder
  import hbd_pkg::*;
#(
  parameter int         AW       = 32,
  parameter int         DW       = 32,
  parameter int         NWIN     = 3,
  parameter logic [7:0] ROOT_BUS = 8'h00,
  localparam int PGW = AW - 12,
  localparam int EHW = AW - 28,
  localparam int BW  = DW / 8,
  localparam int NFN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_req_valid,
  input  logic                h_req_write,
  input  logic [AW-1:0]       h_req_addr,
  input  logic [DW-1:0]       h_req_wdata,
  input  logic [BW-1:0]       h_req_strb,
  output logic                h_rsp_valid,
  output logic [DW-1:0]       h_rsp_rdata,
  output logic                h_rsp_err,
  input  logic [EHW-1:0]      ecam_base_hi,
  input  logic [PGW-1:0]      out_base_pg,
  input  logic [PGW-1:0]      out_limit_pg,
  input  logic [NWIN*PGW-1:0] win_base_pg,
  input  logic [NWIN*PGW-1:0] win_limit_pg,
  input  logic [NFN-1:0]      fn_present,
  output logic                p_req_valid,
  input  logic                p_req_ready,
  output logic [1:0]          p_req_kind,
  output logic [AW-1:0]       p_req_addr,
  output logic [15:0]         p_req_id,
  output logic [11:0]         p_req_reg,
  output logic [BW-1:0]       p_req_be,
  output logic [DW-1:0]       p_req_wdata,
  input  logic                p_cpl_valid,
  input  logic                p_cpl_ur,
  input  logic [DW-1:0]       p_cpl_data
);
  logic       win_hit;
  dec_cls_e   cls;
  req_kind_e  kind, kind_o;
  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [11:0] regoff;

  hbd_win_match #(.AW(AW), .NWIN(NWIN)) win_i (
    .pg       (h_req_addr[AW-1:12]),
    .base_pg  (win_base_pg),
    .limit_pg (win_limit_pg),
    .any_hit  (win_hit)
  );

  hbd_decode #(.AW(AW), .ROOT_BUS(ROOT_BUS)) dec_i (
    .write        (h_req_write),
    .addr         (h_req_addr),
    .ecam_base_hi (ecam_base_hi),
    .out_base_pg  (out_base_pg),
    .out_limit_pg (out_limit_pg),
    .win_hit      (win_hit),
    .fn_present   (fn_present),
    .cls          (cls),
    .kind         (kind),
    .bus          (bus),
    .dev          (dev),
    .fn           (fn),
    .regoff       (regoff)
  );

  hbd_ctrl #(.AW(AW), .DW(DW)) ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_req_valid (h_req_valid),
    .h_req_addr  (h_req_addr),
    .h_req_wdata (h_req_wdata),
    .h_req_strb  (h_req_strb),
    .cls         (cls),
    .kind        (kind),
    .cfg_id      ({bus, dev, fn}),
    .cfg_reg     (regoff),
    .h_rsp_valid (h_rsp_valid),
    .h_rsp_rdata (h_rsp_rdata),
    .h_rsp_err   (h_rsp_err),
    .p_req_valid (p_req_valid),
    .p_req_ready (p_req_ready),
    .p_req_kind  (kind_o),
    .p_req_addr  (p_req_addr),
    .p_req_id    (p_req_id),
    .p_req_reg   (p_req_reg),
    .p_req_be    (p_req_be),
    .p_req_wdata (p_req_wdata),
    .p_cpl_valid (p_cpl_valid),
    .p_cpl_ur    (p_cpl_ur),
    .p_cpl_data  (p_cpl_data)
  );

  assign p_req_kind = kind_o;

  // R4: a locally rejected access never leaves a request behind it
  a_r4_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && h_rsp_err && !$past(p_req_valid)) |-> !p_req_valid);
endmodule

// File: tb/ecam_host_decoder_tb_top.sv
module ecam_host_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_req_valid, h_req_write;
  logic [31:0] h_req_addr, h_req_wdata;
  logic [3:0]  h_req_strb;
  logic        h_rsp_valid, h_rsp_err;
  logic [31:0] h_rsp_rdata;
  logic [3:0]  ecam_base_hi;
  logic [19:0] out_base_pg, out_limit_pg;
  logic [59:0] win_base_pg, win_limit_pg;
  logic [255:0] fn_present;
  logic        p_req_valid, p_req_ready;
  logic [1:0]  p_req_kind;
  logic [31:0] p_req_addr, p_req_wdata;
  logic [15:0] p_req_id;
  logic [11:0] p_req_reg;
  logic [3:0]  p_req_be;
  logic        p_cpl_valid, p_cpl_ur;
  logic [31:0] p_cpl_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [97:0] exp_req_q[$];
  string       exp_req_tag[$];
  logic [32:0] exp_rsp_q[$];
  string       exp_rsp_tag[$];

  logic [31:0] cpl_data_v;
  bit          cpl_ur_v;
  int          pend;

  always #4 clk = ~clk;   // 125 MHz

  ecam_host_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_write(h_req_write), .h_req_addr(h_req_addr),
    .h_req_wdata(h_req_wdata), .h_req_strb(h_req_strb),
    .h_rsp_valid(h_rsp_valid), .h_rsp_rdata(h_rsp_rdata), .h_rsp_err(h_rsp_err),
    .ecam_base_hi(ecam_base_hi), .out_base_pg(out_base_pg), .out_limit_pg(out_limit_pg),
    .win_base_pg(win_base_pg), .win_limit_pg(win_limit_pg), .fn_present(fn_present),
    .p_req_valid(p_req_valid), .p_req_ready(p_req_ready), .p_req_kind(p_req_kind),
    .p_req_addr(p_req_addr), .p_req_id(p_req_id), .p_req_reg(p_req_reg),
    .p_req_be(p_req_be), .p_req_wdata(p_req_wdata),
    .p_cpl_valid(p_cpl_valid), .p_cpl_ur(p_cpl_ur), .p_cpl_data(p_cpl_data)
  );

  function automatic logic [31:0] ecam(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [11:0] r);
    return {4'h3, b, d, f, r};
  endfunction

  function automatic logic [97:0] mk_req(input logic [1:0] k, input logic [31:0] a,
      input logic [15:0] id, input logic [11:0] r, input logic [3:0] be, input logic [31:0] wd);
    return {k, a, id, r, be, wd};
  endfunction

  // completer model
  initial begin
    p_req_ready = 1'b0; p_cpl_valid = 1'b0; p_cpl_ur = 1'b0; p_cpl_data = '0; pend = 0;
    forever begin
      @(posedge clk); #1;
      p_cpl_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          p_cpl_valid = 1'b1; p_cpl_ur = cpl_ur_v; p_cpl_data = cpl_data_v;
        end
      end
      if (p_req_ready) p_req_ready = 1'b0;
      else if (p_req_valid) begin
        p_req_ready = 1'b1;
        if (p_req_kind != 2'd3) pend = 2;
      end
    end
  end

  // request monitor
  always @(negedge clk) begin
    if (rst_n && p_req_valid && p_req_ready) begin
      logic [97:0] got;
      got = {p_req_kind, p_req_addr, p_req_id, p_req_reg, p_req_be, p_req_wdata};
      checks++;
      if (exp_req_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request (R4/R6/R7) actual=%h expected=none", got);
      end else begin
        logic [97:0] e;
        string t;
        e = exp_req_q.pop_front(); t = exp_req_tag.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s request actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && h_rsp_valid) begin
      logic [32:0] got;
      got = {h_rsp_err, h_rsp_rdata};
      checks++;
      if (exp_rsp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected response (R10) actual=%h expected=none", got);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_rsp_q.pop_front(); t = exp_rsp_tag.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s response actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
      input logic [3:0] sb, input bit has_req, input logic [97:0] ereq,
      input logic [31:0] cdata, input bit cur, input logic [31:0] erd, input bit eerr,
      input string tag);
    if (has_req) begin exp_req_q.push_back(ereq); exp_req_tag.push_back(tag); end
    exp_rsp_q.push_back({eerr, erd}); exp_rsp_tag.push_back(tag);
    cpl_data_v = cdata; cpl_ur_v = cur;
    @(posedge clk); #1;
    h_req_valid = 1'b1; h_req_write = wr; h_req_addr = a; h_req_wdata = wd; h_req_strb = sb;
    do begin @(posedge clk); #1; end while (!h_rsp_valid);
    h_req_valid = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; h_req_valid = 1'b0; h_req_write = 1'b0; h_req_addr = '0;
    h_req_wdata = '0; h_req_strb = '0;
    ecam_base_hi = 4'h3;
    out_base_pg = 20'h40000; out_limit_pg = 20'h7FFFF;
    // window 2: base above limit (disabled); window 1: single page; window 0: 16 MiB
    win_base_pg  = {20'h60000, 20'h50000, 20'h40000};
    win_limit_pg = {20'h5FFFF, 20'h50000, 20'h40FFF};
    fn_present = '0;
    fn_present[{5'd0, 3'd0}] = 1'b1;
    fn_present[{5'd1, 3'd0}] = 1'b1;
    fn_present[{5'd3, 3'd2}] = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (p_req_valid !== 1'b0 || h_rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset outputs actual=%b%b expected=00", p_req_valid, h_rsp_valid);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 / R8: root-bus config read to present function
    access(0, ecam(8'd0, 5'd1, 3'd0, 12'h010), 32'h0, 4'hF, 1,
           mk_req(2'd0, ecam(8'd0, 5'd1, 3'd0, 12'h010), {8'd0, 5'd1, 3'd0}, 12'h010, 4'hF, 32'h0),
           32'h1234_5678, 0, 32'h1234_5678, 0, "R1");
    // R1: other bus, top field values, no presence check
    access(0, ecam(8'd5, 5'd31, 3'd7, 12'hFFC), 32'h0, 4'hF, 1,
           mk_req(2'd0, ecam(8'd5, 5'd31, 3'd7, 12'hFFC), {8'd5, 5'd31, 3'd7}, 12'hFFC, 4'hF, 32'h0),
           32'hCAFE_0001, 0, 32'hCAFE_0001, 0, "R1");
    // R2: config write with partial strobe
    access(1, ecam(8'd0, 5'd3, 3'd2, 12'h004), 32'hA5A5_0F0F, 4'h3, 1,
           mk_req(2'd1, ecam(8'd0, 5'd3, 3'd2, 12'h004), {8'd0, 5'd3, 3'd2}, 12'h004, 4'h3, 32'hA5A5_0F0F),
           32'h0, 0, 32'h0, 0, "R2");
    // R6: absent function on root bus
    access(0, ecam(8'd0, 5'd2, 3'd0, 12'h000), 32'h0, 4'hF, 0, '0,
           32'h0, 0, 32'hFFFF_FFFF, 0, "R6");
    // R7: write to absent function dropped
    access(1, ecam(8'd0, 5'd9, 3'd1, 12'h008), 32'h1111_2222, 4'hF, 0, '0,
           32'h0, 0, 32'h0, 0, "R7");
    // R8: config read completing with Unsupported Request
    access(0, ecam(8'd0, 5'd0, 3'd0, 12'h100), 32'h0, 4'hF, 1,
           mk_req(2'd0, ecam(8'd0, 5'd0, 3'd0, 12'h100), 16'h0000, 12'h100, 4'hF, 32'h0),
           32'h0BAD_0BAD, 1, 32'hFFFF_FFFF, 0, "R8");
    // R3: memory read in window 0
    access(0, 32'h4000_1230, 32'h0, 4'hF, 1,
           mk_req(2'd2, 32'h4000_1230, 16'h0, 12'h0, 4'hF, 32'h0),
           32'h7777_8888, 0, 32'h7777_8888, 0, "R3");
    // R11 / R5: posted write at last byte of single-page window 1
    access(1, 32'h5000_0FFC, 32'hDEAD_BEEF, 4'hC, 1,
           mk_req(2'd3, 32'h5000_0FFC, 16'h0, 12'h0, 4'hC, 32'hDEAD_BEEF),
           32'h0, 0, 32'h0, 0, "R11");
    // R5: first byte past window 1 limit
    access(0, 32'h5000_1000, 32'h0, 4'hF, 0, '0, 32'h0, 0, 32'h0, 1, "R5");
    // R5: disabled window
    access(0, 32'h6000_0000, 32'h0, 4'hF, 0, '0, 32'h0, 0, 32'h0, 1, "R5");
    // R4: outbound region but no window
    access(1, 32'h4800_0000, 32'h1, 4'hF, 0, '0, 32'h0, 0, 32'h0, 1, "R4");
    // R4: outside every region
    access(0, 32'h1000_0000, 32'h0, 4'hF, 0, '0, 32'h0, 0, 32'h0, 1, "R4");
    // R9: memory read with Unsupported Request
    access(0, 32'h40FF_FFF0, 32'h0, 4'hF, 1,
           mk_req(2'd2, 32'h40FF_FFF0, 16'h0, 12'h0, 4'hF, 32'h0),
           32'h5555_5555, 1, 32'h0, 1, "R9");

    repeat (10) @(posedge clk);
    // R10: every expected request and response was produced
    checks++;
    if (exp_req_q.size() != 0 || exp_rsp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 leftover items actual=%0d/%0d expected=0/0",
               exp_req_q.size(), exp_rsp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule